// File: doc/BRIEF.md
# Probe-Mode Debug Controller

This block models the probe execution mode of a processor core. A debug host drives it through an abstract parallel command port: an opcode, a write word and a one-cycle strobe, with a registered read word returned. The block keeps a mode control register, a write-only instruction register of 16 bytes and two 64-bit result registers. It decides when the core is in probe mode and hands instructions to an execution-unit stub over a valid/ready handshake.

Probe mode can be entered in three ways. The first is the run/stop level input. The second is an interrupt that arrives while the redirect flag is set. The third is an explicit enter command. Only an exit command leaves the mode. The instruction and result registers can be reached only while in probe mode. The instruction register can never be read back. Once the stub takes an instruction, the register refills itself with 0x90 no-operation bytes. The stub returns results through a result-write port into either of the two result registers.

Top module: `probe_debug_ctrl`

## Requirements
- R1: After reset, in_probe, instr_valid and cmd_rdata are 0. The control word reads 0. An instruction issued with no prior write carries 0x90 in all 16 bytes.
- R2: While out of probe mode, in_probe rises on the clock after any of these events: run_stop high, irq high while the redirect flag is 1, or an enter command (opcode 1). An irq with the redirect flag at 0 has no effect.
- R3: Only the exit command (opcode 2) clears in_probe, on the next clock. An enter command given while in probe mode changes nothing and raises no error.
- R4: The control word is read with opcode 4 and written with opcode 3 in any mode. Bit 0 is the redirect flag, bit 1 is in_probe, bit 2 is the access-error flag and bit 3 is the busy flag. A write loads bit 0 from the write word and clears the error and busy flags. Read data appears on cmd_rdata on the clock after the strobe.
- R5: Outside probe mode, the gated opcodes (5 to 12) have no effect and return 0, and each one sets the access-error flag.
- R6: Opcode 5 writes instruction bytes 0 to 7 and opcode 6 writes bytes 8 to 15. Byte k sits in instr_data bits 8k+7 to 8k.
- R7: A read of the instruction register (opcode 7) returns 0 and sets the access-error flag, in every mode.
- R8: In probe mode, the execute command (opcode 8) raises instr_valid on the next clock with the register contents on instr_data. Both are held steady until instr_ready is seen.
- R9: On the clock that samples instr_valid and instr_ready both high, instr_valid falls and every instruction byte becomes 0x90.
- R10: While an instruction is pending, an execute command or an instruction write is dropped and sets the busy flag.
- R11: A result write (res_we, with res_idx 0 or 1) loads that result register only in probe mode. Outside probe mode it is ignored.
- R12: In probe mode, result registers 0 and 1 are read with opcodes 9 and 10 and written with opcodes 11 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_strobe | input | 1 | Command valid for one cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_wdata | input | 64 | Command write word |
| cmd_rdata | output | 64 | Registered read word |
| run_stop | input | 1 | Level request to enter probe mode |
| irq | input | 1 | Interrupt; enters probe mode when redirect is set |
| in_probe | output | 1 | Probe mode active |
| instr_valid | output | 1 | Instruction offered to the stub |
| instr_ready | input | 1 | Stub accepts the instruction |
| instr_data | output | 128 | Instruction bytes |
| res_we | input | 1 | Result write from the stub |
| res_idx | input | 1 | Result register index |
| res_data | input | 64 | Result word |

## Verification
Directed passes try each entry trigger on its own. They include irq with the redirect flag both clear and set, which shows whether the flag actually gates the interrupt path. Gated opcodes are sent before and after entry, which separates mode gating from plain decode. Commands that collide with a pending instruction show whether drops keep the held data intact. A seeded random run then mixes lane writes and issues with varying stub delays, checking issued data against a bench model that refills with no-ops. Result registers are filled from the stub and from the command port, then read back across an exit to show that stub writes are gated.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef enum logic [3:0] {
    OP_IDLE        = 4'd0,
    OP_ENTER       = 4'd1,
    OP_EXIT        = 4'd2,
    OP_CTRL_WR     = 4'd3,
    OP_CTRL_RD     = 4'd4,
    OP_INSTR_WR_LO = 4'd5,
    OP_INSTR_WR_HI = 4'd6,
    OP_INSTR_RD    = 4'd7,
    OP_EXEC        = 4'd8,
    OP_DATA0_RD    = 4'd9,
    OP_DATA1_RD    = 4'd10,
    OP_DATA0_WR    = 4'd11,
    OP_DATA1_WR    = 4'd12
  } probe_op_e;

  // Opcodes that need probe mode.
  function automatic logic needs_probe(input probe_op_e op);
    return (op >= OP_INSTR_WR_LO) && (op <= OP_DATA1_WR);
  endfunction

  // Control word layout: {busy, err, in_probe, redirect}.
  function automatic logic [3:0] pack_ctrl(input logic redirect, input logic probe,
                                           input logic err, input logic busy);
    return {busy, err, probe, redirect};
  endfunction
endpackage

// File: rtl/probe_mode_fsm.sv
module probe_mode_fsm (
  input  logic clk,
  input  logic rst,
  input  logic enter_cmd,
  input  logic exit_cmd,
  input  logic run_stop,
  input  logic irq,
  input  logic redirect,
  output logic in_probe,
  output logic enter_evt
);
  logic probe_q;

  assign enter_evt = enter_cmd | run_stop | (irq & redirect);
  assign in_probe  = probe_q;

  always_ff @(posedge clk) begin
    if (rst)               probe_q <= 1'b0;
    else if (probe_q)      probe_q <= !exit_cmd;
    else if (enter_evt)    probe_q <= 1'b1;
  end

  assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
    (!probe_q && enter_evt) |=> probe_q);
  assert_stay_R3: assert property (@(posedge clk) disable iff (rst)
    (probe_q && !exit_cmd) |=> probe_q);
endmodule

// File: rtl/probe_instr_reg.sv
module probe_instr_reg #(
  parameter int NBYTES = 16,
  parameter int LANE_W = 64,
  localparam int IW     = NBYTES * 8,
  localparam int NLANES = IW / LANE_W,
  localparam int LSEL_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LSEL_W-1:0] wr_lane,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              exec_req,
  input  logic              instr_ready,
  output logic              instr_valid,
  output logic [IW-1:0]     instr_data,
  output logic              drop_evt
);
  function automatic logic [IW-1:0] nop_fill();
    logic [IW-1:0] f;
    for (int b = 0; b < NBYTES; b++) f[8*b +: 8] = 8'h90;
    return f;
  endfunction

  localparam logic [IW-1:0] NOPS = nop_fill();

  logic pending_q;
  logic accept_evt;
  logic lane_wr_ok;

  assign accept_evt = pending_q & instr_ready;
  assign drop_evt   = pending_q & (exec_req | wr_en);
  assign lane_wr_ok = wr_en & !pending_q;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)                    lane_q <= NOPS[l*LANE_W +: LANE_W];
      else if (accept_evt)        lane_q <= NOPS[l*LANE_W +: LANE_W];
      else if (lane_wr_ok && wr_lane == LSEL_W'(l)) lane_q <= wr_data;
    end
    assign instr_data[l*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst)             pending_q <= 1'b0;
    else if (accept_evt) pending_q <= 1'b0;
    else if (exec_req)   pending_q <= 1'b1;
  end

  assign instr_valid = pending_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !instr_ready) |=> (instr_valid && $stable(instr_data)));
  assert_refill_R9: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> (!instr_valid && instr_data == NOPS));
endmodule

// File: rtl/probe_data_regs.sv
module probe_data_regs #(
  parameter int DATA_W = 64,
  parameter int NREGS  = 2,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_probe,
  input  logic                         host_we,
  input  logic [IDX_W-1:0]             host_idx,
  input  logic [DATA_W-1:0]            host_data,
  input  logic                         res_we,
  input  logic [IDX_W-1:0]             res_idx,
  input  logic [DATA_W-1:0]            res_data,
  output logic [NREGS-1:0][DATA_W-1:0] regs
);
  logic res_ok;
  assign res_ok = res_we & in_probe;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                    q <= '0;
      else if (res_ok && res_idx == IDX_W'(r))    q <= res_data;
      else if (host_we && host_idx == IDX_W'(r))  q <= host_data;
    end
    assign regs[r] = q;
  end

  assert_gated_R11: assert property (@(posedge clk) disable iff (rst)
    (res_we && !in_probe && !host_we) |=> $stable(regs));
endmodule

// File: rtl/probe_debug_ctrl.sv
module probe_debug_ctrl #(
  parameter int INSTR_BYTES = 16,
  parameter int DATA_W      = 64,
  localparam int IW         = INSTR_BYTES * 8,
  localparam int NLANES     = IW / DATA_W,
  localparam int LSEL_W     = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_strobe,
  input  logic [3:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] cmd_rdata,
  input  logic              run_stop,
  input  logic              irq,
  output logic              in_probe,
  output logic              instr_valid,
  input  logic              instr_ready,
  output logic [IW-1:0]     instr_data,
  input  logic              res_we,
  input  logic              res_idx,
  input  logic [DATA_W-1:0] res_data
);
  import probe_pkg::*;

  probe_op_e op;
  logic gated, allowed, acc_err_evt, busy_evt, enter_evt;
  logic redirect_q, err_q, busy_q;
  logic ctrl_wr;
  logic [1:0][DATA_W-1:0] pdr;

  assign op          = probe_op_e'(cmd_op);
  assign gated       = needs_probe(op);
  assign allowed     = cmd_strobe && (!gated || in_probe) && (op != OP_INSTR_RD);
  assign acc_err_evt = cmd_strobe && ((gated && !in_probe) || op == OP_INSTR_RD);
  assign ctrl_wr     = cmd_strobe && op == OP_CTRL_WR;

  probe_mode_fsm u_fsm (
    .clk(clk), .rst(rst),
    .enter_cmd(cmd_strobe && op == OP_ENTER),
    .exit_cmd(cmd_strobe && op == OP_EXIT),
    .run_stop(run_stop), .irq(irq), .redirect(redirect_q),
    .in_probe(in_probe), .enter_evt(enter_evt)
  );

  probe_instr_reg #(.NBYTES(INSTR_BYTES), .LANE_W(DATA_W)) u_instr (
    .clk(clk), .rst(rst),
    .wr_en(allowed && (op == OP_INSTR_WR_LO || op == OP_INSTR_WR_HI)),
    .wr_lane((op == OP_INSTR_WR_HI) ? LSEL_W'(1) : LSEL_W'(0)),
    .wr_data(cmd_wdata),
    .exec_req(allowed && op == OP_EXEC),
    .instr_ready(instr_ready),
    .instr_valid(instr_valid),
    .instr_data(instr_data),
    .drop_evt(busy_evt)
  );

  probe_data_regs #(.DATA_W(DATA_W), .NREGS(2)) u_data (
    .clk(clk), .rst(rst), .in_probe(in_probe),
    .host_we(allowed && (op == OP_DATA0_WR || op == OP_DATA1_WR)),
    .host_idx(op == OP_DATA1_WR),
    .host_data(cmd_wdata),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
    .regs(pdr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_q <= 1'b0;
      err_q      <= 1'b0;
      busy_q     <= 1'b0;
    end else if (ctrl_wr) begin
      redirect_q <= cmd_wdata[0];
      err_q      <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      if (acc_err_evt) err_q  <= 1'b1;
      if (busy_evt)    busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_rdata <= '0;
    else if (cmd_strobe) begin
      unique case (op)
        OP_CTRL_RD:  cmd_rdata <= DATA_W'(pack_ctrl(redirect_q, in_probe, err_q, busy_q));
        OP_DATA0_RD: cmd_rdata <= allowed ? pdr[0] : '0;
        OP_DATA1_RD: cmd_rdata <= allowed ? pdr[1] : '0;
        default:     cmd_rdata <= '0;
      endcase
    end
  end

  assert_pir_unreadable_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && op == OP_INSTR_RD) |=> (cmd_rdata == '0 && err_q));
  assert_gate_err_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && gated && !in_probe) |=> (err_q && cmd_rdata == '0));
  assert_ctrl_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (!err_q && !busy_q));
  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_probe && !enter_evt) |=> !in_probe);
endmodule

// File: tb/probe_debug_ctrl_test.sv
module probe_debug_ctrl_test;
  import probe_pkg::*;

  logic clk = 0, rst = 1;
  logic cmd_strobe = 0;
  logic [3:0] cmd_op = 0;
  logic [63:0] cmd_wdata = 0, cmd_rdata;
  logic run_stop = 0, irq = 0, in_probe, instr_valid, instr_ready = 0;
  logic [127:0] instr_data;
  logic res_we = 0, res_idx = 0;
  logic [63:0] res_data = 0;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  probe_debug_ctrl uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [127:0] nops();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'h90;
    return v;
  endfunction

  function automatic logic [63:0] ctrl_exp(bit red, bit pr, bit er, bit bz);
    return 64'(red) | (64'(pr) << 1) | (64'(er) << 2) | (64'(bz) << 3);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  // All tasks start just after a falling edge and end on one.
  task automatic cmd(probe_op_e op, logic [63:0] wd = 0);
    cmd_strobe = 1; cmd_op = op; cmd_wdata = wd;
    @(negedge clk);
    cmd_strobe = 0; cmd_op = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic accept();
    instr_ready = 1;
    @(negedge clk);
    instr_ready = 0;
  endtask

  task automatic stub_write(bit idx, logic [63:0] d);
    res_we = 1; res_idx = idx; res_data = d;
    @(negedge clk);
    res_we = 0;
  endtask

  logic [127:0] model;
  logic [63:0] p0, p1, a, b;

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_probe", in_probe, 0);
    chk("R1 instr_valid", instr_valid, 0);
    chk("R1 rdata", cmd_rdata, 0);
    cmd(OP_CTRL_RD); chk("R1 R4 ctrl", cmd_rdata, 0);

    // R5 gated access outside probe mode
    cmd(OP_INSTR_WR_LO, 64'h1111);
    cmd(OP_EXEC);
    chk("R5 no issue", instr_valid, 0);
    cmd(OP_DATA0_RD); chk("R5 data read zero", cmd_rdata, 0);
    cmd(OP_CTRL_RD); chk("R5 err set", cmd_rdata, ctrl_exp(0, 0, 1, 0));
    cmd(OP_CTRL_WR, 0);
    cmd(OP_CTRL_RD); chk("R4 err cleared", cmd_rdata, 0);

    // R2 triggers
    irq = 1; @(negedge clk); irq = 0;
    chk("R2 irq masked", in_probe, 0);
    cmd(OP_CTRL_WR, 1);
    irq = 1; @(negedge clk); irq = 0;
    chk("R2 irq redirect", in_probe, 1);
    cmd(OP_ENTER);
    cmd(OP_CTRL_RD); chk("R3 reenter ignored", cmd_rdata, ctrl_exp(1, 1, 0, 0));
    idle(2);
    chk("R3 stays", in_probe, 1);
    cmd(OP_EXIT); chk("R3 exit", in_probe, 0);
    run_stop = 1; @(negedge clk); run_stop = 0;
    chk("R2 run_stop", in_probe, 1);
    cmd(OP_EXIT);
    cmd(OP_ENTER); chk("R2 enter cmd", in_probe, 1);

    // R1 R8 issue of untouched register
    cmd(OP_EXEC);
    chk("R8 valid", instr_valid, 1);
    chk("R1 nop contents", instr_data, nops());
    idle(3);
    chk("R8 held", instr_valid, 1);
    cmd(OP_EXEC);
    cmd(OP_CTRL_RD); chk("R10 busy", cmd_rdata, ctrl_exp(1, 1, 0, 1));
    accept();
    chk("R9 valid drops", instr_valid, 0);
    cmd(OP_CTRL_WR, 1);

    // R6 R7 lane writes and unreadable register
    cmd(OP_INSTR_WR_LO, 64'h0706050403020100);
    cmd(OP_INSTR_WR_HI, 64'h900e0d0c0b0a0908);
    cmd(OP_INSTR_RD); chk("R7 read zero", cmd_rdata, 0);
    cmd(OP_CTRL_RD); chk("R7 err", cmd_rdata, ctrl_exp(1, 1, 1, 0));
    cmd(OP_CTRL_WR, 1);
    cmd(OP_EXEC);
    chk("R6 lanes", instr_data, 128'h900e0d0c0b0a0908_0706050403020100);
    cmd(OP_INSTR_WR_LO, 64'hdead);
    chk("R10 write dropped", instr_data, 128'h900e0d0c0b0a0908_0706050403020100);
    cmd(OP_CTRL_RD); chk("R10 busy on write", cmd_rdata, ctrl_exp(1, 1, 0, 1));
    accept();
    cmd(OP_CTRL_WR, 1);
    cmd(OP_EXEC);
    chk("R9 refilled", instr_data, nops());
    accept();

    // Random lane writes and issues against a model
    model = nops();
    for (int it = 0; it < 40; it++) begin
      int k;
      k = $urandom_range(0, 3);
      if (k[0]) begin a = {$urandom, $urandom}; cmd(OP_INSTR_WR_LO, a); model[63:0] = a; end
      if (k[1]) begin b = {$urandom, $urandom}; cmd(OP_INSTR_WR_HI, b); model[127:64] = b; end
      cmd(OP_EXEC);
      chk("R6 R8 random issue", {127'(0), instr_valid} | (128'(instr_data) << 1), {127'(0), 1'b1} | (model << 1));
      idle($urandom_range(0, 3));
      chk("R8 random hold", instr_data, model);
      accept();
      model = nops();
      chk("R9 random drop", instr_valid, 0);
    end

    // R11 R12 result registers
    p0 = {$urandom, $urandom}; p1 = {$urandom, $urandom};
    stub_write(0, p0); stub_write(1, p1);
    cmd(OP_DATA0_RD); chk("R11 R12 data0", cmd_rdata, p0);
    cmd(OP_DATA1_RD); chk("R11 R12 data1", cmd_rdata, p1);
    p1 = {$urandom, $urandom};
    cmd(OP_DATA1_WR, p1);
    cmd(OP_DATA1_RD); chk("R12 host write", cmd_rdata, p1);
    cmd(OP_EXIT);
    stub_write(0, ~p0);
    cmd(OP_DATA1_WR, 64'h5);
    cmd(OP_ENTER);
    cmd(OP_DATA0_RD); chk("R11 ignored outside", cmd_rdata, p0);
    cmd(OP_DATA1_RD); chk("R5 host write ignored", cmd_rdata, p1);

    finish_run();
  end
endmodule